// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD bytes. The fields are seconds, minutes, hours, date, month, a two-digit year, a century byte and an independent day-of-week count. A base tick input is divided by a parameterised prescaler (`TICKS_PER_SEC`) into one-second steps. Each step advances the whole calendar, with every carry resolved in that same step, so the register never shows a half-updated time.

The register access logic writes a complete new time through a parallel load port after a committed write. A load replaces every field in one cycle and restarts the sub-second prescaler. The full 64-bit time word is always presented for readout and for alarm comparison. The hour byte carries a stored format flag in bit 7. The counter keeps that flag unchanged and always counts hours on a 24-hour basis.

Each cycle the top level selects one of three actions: `ACT_LOAD` (the load strobe is high), `ACT_STEP` (a second boundary is reached) or `ACT_IDLE` (otherwise). The transitions are: from reset to the reset image; `ACT_LOAD`, which gives priority to a load over a step; `ACT_STEP`, which commits the fully rippled next time; and `ACT_IDLE`, which holds the register.

Top module: `bcd_cal_counter`

## Requirements
- R1: While reset is low, and after it is released, `time_o` equals 64'h2000_0000_0000_0000: the century byte is 0x20 and every other byte is 0x00.
- R2: The time advances by one second on every `TICKS_PER_SEC`-th `tick_in` pulse counted since reset or since the last load. With neither a tick nor a load, `time_o` does not change.
- R3: Seconds (byte 0) and minutes (byte 1) count in BCD from 0x00 to 0x59. Seconds wrap to 0x00 and step the minutes, and minutes wrap to 0x00 and step the hours.
- R4: Hours (byte 2, bits 5:0) count in BCD from 0x00 to 0x23 and then wrap to 0x00, stepping the date. Bit 7 of byte 2 is a format flag that counting never changes.
- R5: Date (byte 3) counts from 0x01 up to the month's last day and then wraps to 0x01, stepping the month. Months 04, 06, 09 and 11 have 30 days and February has 29 days when the year value is divisible by 4 (28 otherwise). All other months have 31 days.
- R6: Month (byte 4) counts 0x01 to 0x12 and then wraps to 0x01, stepping the year. Year (byte 5) counts 0x00 to 0x99 and then wraps to 0x00, stepping the century (byte 7) in BCD, for example 0x19 to 0x20.
- R7: Day of week (byte 6, bits 2:0) steps once on every date change and wraps from 6 to 0, whatever the date value.
- R8: A load stores `ld_time` in one cycle, masked per byte (century 0xFF, day of week 0x07, year 0xFF, month 0x1F, date 0x3F, hour 0xBF, minutes 0x7F, seconds 0x7F). It restarts the prescaler, and a tick in the same cycle is ignored.
- R9: A second step that carries through every field (for example 1999-12-31 23:59:59) gives the fully updated time on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Base tick pulse, `TICKS_PER_SEC` per second |
| ld_en | input | 1 | Load strobe from the register access logic |
| ld_time | input | 64 | New time, bytes: 7 century, 6 day of week, 5 year, 4 month, 3 date, 2 hour, 1 minutes, 0 seconds |
| time_o | output | 64 | Current time in the same byte layout |

## Verification
Every result is registered once. A load, or the tick that completes a second, appears on `time_o` after the next rising edge. Ticks that do not complete a second leave it unchanged. The bench drives each stimulus at a falling edge and samples `time_o` at the following falling edge, one cycle later, against an integer calendar model. That model tracks its own prescaler phase and is reset to phase zero on every load. Sweeps cover two hours of seconds, the hour rollover with the format flag set, and the last day of every month in leap and common years. A century wrap and a load taken in the middle of a second are also covered.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] dow;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } cal_act_e;

    localparam logic [63:0] CAL_RESET_WORD = 64'h2000_0000_0000_0000;
    localparam logic [63:0] CAL_LOAD_MASK  = 64'hFF07_FF1F_3FBF_7F7F;

    // Increment a two-digit BCD byte (caller handles the top value).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic restart,
    output logic sec_pulse
);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            logic unused_ok;
            assign unused_ok = ^{clk, rst_n};
            assign sec_pulse = tick_in & ~restart;
        end else begin : g_count
            localparam int CW = $clog2(TICKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
            logic [CW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    phase_q <= '0;
                end else if (tick_in) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign sec_pulse = tick_in & ~restart & (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_day
);

    logic leap;

    // BCD year divisible by 4: even tens -> units 0/4/8, odd tens -> units 2/6.
    always_comb begin
        if (!year[4]) begin
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        end else begin
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        end
    end

    always_comb begin
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/cal_time_next.sv
module cal_time_next
    import cal_pkg::*;
(
    input  cal_time_t  cur,
    input  logic [7:0] last_day,
    output cal_time_t  nxt
);

    logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;
    logic [7:0] hr_cnt;

    assign hr_cnt = {2'b00, cur.hour[5:0]};

    assign c_min = (cur.sec == 8'h59);
    assign c_hr  = c_min && (cur.min == 8'h59);
    assign c_day = c_hr && (hr_cnt == 8'h23);
    assign c_mon = c_day && (cur.date == last_day);
    assign c_yr  = c_mon && (cur.month == 8'h12);
    assign c_cen = c_yr && (cur.year == 8'h99);

    always_comb begin
        nxt = cur;
        nxt.sec = c_min ? 8'h00 : bcd_inc(cur.sec);
        if (c_min) begin
            nxt.min = c_hr ? 8'h00 : bcd_inc(cur.min);
        end
        if (c_hr) begin
            nxt.hour = {cur.hour[7], 1'b0, c_day ? 6'h00 : bcd_inc(hr_cnt)[5:0]};
        end
        if (c_day) begin
            nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
            nxt.dow  = {5'd0, (cur.dow[2:0] == 3'd6) ? 3'd0 : cur.dow[2:0] + 3'd1};
        end
        if (c_mon) begin
            nxt.month = c_yr ? 8'h01 : bcd_inc(cur.month);
        end
        if (c_yr) begin
            nxt.year = c_cen ? 8'h00 : bcd_inc(cur.year);
        end
        if (c_cen) begin
            nxt.cen = bcd_inc(cur.cen);
        end
    end

endmodule

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_in,
    input  logic        ld_en,
    input  logic [63:0] ld_time,
    output logic [63:0] time_o
);

    cal_time_t  cur_q;
    cal_time_t  nxt;
    cal_act_e   act;
    logic       sec_pulse;
    logic [7:0] last_day;

    cal_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .restart   (ld_en),
        .sec_pulse (sec_pulse)
    );

    cal_month_len u_mlen (
        .month    (cur_q.month),
        .year     (cur_q.year),
        .last_day (last_day)
    );

    cal_time_next u_next (
        .cur      (cur_q),
        .last_day (last_day),
        .nxt      (nxt)
    );

    always_comb begin
        if (ld_en) begin
            act = ACT_LOAD;
        end else if (sec_pulse) begin
            act = ACT_STEP;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= cal_time_t'(CAL_RESET_WORD);
        end else begin
            unique case (act)
                ACT_LOAD: cur_q <= cal_time_t'(ld_time & CAL_LOAD_MASK);
                ACT_STEP: cur_q <= nxt;
                ACT_IDLE: cur_q <= cur_q;
                default:  cur_q <= cur_q;
            endcase
        end
    end

    assign time_o = cur_q;

endmodule

// File: rtl/cal_checker.sv
module cal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_in,
    input logic        ld_en,
    input logic [63:0] ld_time,
    input logic [63:0] time_o
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !ld_en) |=> $stable(time_o)); // R2

    AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (time_o == ($past(ld_time) & 64'hFF07_FF1F_3FBF_7F7F))); // R8

    AST_FMT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> (time_o[23] == $past(time_o[23]))); // R4

    AST_MIN_ONLY_AT_59: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && time_o[7:0] != 8'h59) |=> $stable(time_o[15:8])); // R3

    AST_CEN_ONLY_AT_99: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && time_o[47:40] != 8'h99) |=> $stable(time_o[63:56])); // R6

    AST_DOW_WITH_DATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> ($stable(time_o[31:24]) == $stable(time_o[55:48]))); // R7

endmodule

bind bcd_cal_counter cal_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .ld_en   (ld_en),
    .ld_time (ld_time),
    .time_o  (time_o)
);

// File: tb/bcd_cal_counter_tb.sv
module bcd_cal_counter_tb;

    localparam int TPS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        ld_en = 1'b0;
    logic [63:0] ld_time = '0;
    logic [63:0] time_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    int s, m, h, d, mo, y, c, w, fmt, sub;

    always #5 clk = ~clk;

    bcd_cal_counter #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .ld_en(ld_en), .ld_time(ld_time), .time_o(time_o)
    );

    function automatic logic [7:0] bcd(input int x);
        return 8'(((x / 10) * 16) + (x % 10));
    endfunction

    function automatic int unbcd(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int mlen(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] exp_word();
        return {bcd(c), 8'(w), bcd(y), bcd(mo), bcd(d),
                (bcd(h) | (fmt != 0 ? 8'h80 : 8'h00)), bcd(m), bcd(s)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_second();
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin
                    h = 0; d++; w = (w + 1) % 7;
                    if (d > mlen(mo, y)) begin
                        d = 1; mo++;
                        if (mo == 13) begin
                            mo = 1; y++;
                            if (y == 100) begin y = 0; c++; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic load(input logic [63:0] v, input bit with_tick);
        @(negedge clk);
        ld_en = 1'b1; ld_time = v; tick_in = with_tick;
        @(negedge clk);
        ld_en = 1'b0; tick_in = 1'b0;
        c = unbcd(v[63:56]); w = int'(v[50:48]); y = unbcd(v[47:40]);
        mo = unbcd(v[39:32]); d = unbcd(v[31:24]); fmt = int'(v[23]);
        h = unbcd({2'b00, v[21:16]}); m = unbcd(v[15:8]); s = unbcd(v[7:0]);
        sub = 0;
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        sub++;
        if (sub == TPS) begin sub = 0; model_second(); end
        chk(tag, time_o, exp_word());
    endtask

    task automatic seconds(input string tag, input int n);
        for (int i = 0; i < n * TPS; i++) tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", time_o, 64'h2000_0000_0000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", time_o, 64'h2000_0000_0000_0000);
        c = 20; w = 0; y = 0; mo = 0; d = 0; h = 0; m = 0; s = 0; fmt = 0; sub = 0;

        // R2: no tick, no change; three ticks do not complete a second
        repeat (10) @(negedge clk);
        chk("R2", time_o, exp_word());
        for (int i = 0; i < TPS - 1; i++) begin
            tick("R2");
            chk("R2", time_o, 64'h2000_0000_0000_0000);
        end
        tick("R2");
        chk("R2", time_o[7:0], 8'h01);

        // R3: two hours of seconds and minutes
        load({8'h20, 8'h02, 8'h24, 8'h05, 8'h14, 8'h10, 8'h00, 8'h00}, 1'b0);
        seconds("R3", 7200);
        chk("R3", time_o[23:0], 24'h120000);

        // R4: hour wrap with format flag held
        load({8'h20, 8'h03, 8'h23, 8'h07, 8'h09, 8'h80 | 8'h23, 8'h58, 8'h30}, 1'b0);
        seconds("R4", 120);
        chk("R4", time_o[23:16], 8'h80);

        // R5 R6 R7: last day of each month, leap and common years
        for (int yi = 0; yi < 4; yi++) begin
            int yy;
            yy = (yi == 0) ? 0 : (yi == 1) ? 23 : (yi == 2) ? 24 : 98;
            for (int mm = 1; mm <= 12; mm++) begin
                load({8'h19, 8'(mm % 7), bcd(yy), bcd(mm), bcd(mlen(mm, yy)),
                      8'h23, 8'h59, 8'h59}, 1'b0);
                seconds("R5", 1);
                chk("R5", time_o[31:24], 8'h01);
                chk("R7", time_o[55:48], 8'((mm % 7 + 1) % 7));
            end
            load({8'h20, 8'h06, bcd(yy), 8'h02, 8'h28, 8'h23, 8'h59, 8'h59}, 1'b0);
            seconds("R5", 1);
            chk("R5", time_o[31:24], (yy % 4 == 0) ? 8'h29 : 8'h01);
            chk("R7", time_o[55:48], 8'h00);
        end

        // R6 R9: full ripple through the century
        load({8'h19, 8'h05, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59}, 1'b0);
        seconds("R9", 1);
        chk("R9", time_o, 64'h2006_0001_0100_0000);
        chk("R6", time_o[63:56], 8'h20);

        // R8: masking of an all-ones load
        load(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        chk("R8", time_o, 64'hFF07_FF1F_3FBF_7F7F);

        // R8: load in mid-second restarts the prescaler; tick with load ignored
        load({8'h20, 8'h01, 8'h30, 8'h06, 8'h15, 8'h08, 8'h00, 8'h00}, 1'b0);
        tick("R8");
        tick("R8");
        load({8'h20, 8'h01, 8'h30, 8'h06, 8'h15, 8'h08, 8'h00, 8'h10}, 1'b1);
        for (int i = 0; i < TPS - 1; i++) tick("R8");
        chk("R8", time_o[7:0], 8'h10);
        tick("R8");
        chk("R8", time_o[7:0], 8'h11);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule